// File: doc/BRIEF.md
# Management-Mode Cache Flush Sequencer

This controller sits next to a processor core and decides when the core's cache has to be flushed around a protected management mode whose private memory overlays the normal address space. It takes a single-cycle management interrupt request, an external flush request, the core's management-active indication and two static cacheability settings, one for normal memory and one for the private memory. It emits a one-cycle flush command to the cache, a one-cycle gated interrupt toward the core, a strobe that marks the two completion bus cycles that close a write-back flush, and its current sequencing state.

On entry, a flush is taken whenever normal memory is cacheable. When the interrupt and a flush request are present together, the flush runs first and the interrupt is held in a pending latch until the flush is complete. A write-back flush waits for the cache to report that every modified line has been written back, then runs two completion cycles, and only then releases the interrupt. On exit, a flush is commanded on the clock that first sees the management-active indication low whenever the private memory was cacheable. The cache is modelled by a done handshake.

Top module: `mgmt_flush_seq`

## Requirements
- R1: Reset (active-low `rst_n`) forces `seq_state` to idle (0), drives `flush_cmd`, `mint_to_core` and `special_cyc` low, and clears any pending interrupt. No interrupt is released after reset unless a new request arrives.
- R2: The cacheability codes are 00 uncached, 01 write-through, and 10 or 11 write-back. In idle, an interrupt request with normal memory cacheable starts an entry flush: `flush_cmd` goes high for one cycle after the request edge, and `mint_to_core` stays low. With normal memory uncached, `mint_to_core` pulses one cycle after the request, no flush is issued, and the state becomes in-mode (4).
- R3: In in-mode, once `mode_active` has been seen high, the first clock that samples it low ends the mode. If the held private setting is cacheable (write-through or write-back), `flush_cmd` is high right after that clock and the state is exit-flush (5) until `cache_done`, then idle. If the held private setting is uncached, no flush is issued and the state returns to idle at that clock.
- R4: When an interrupt request and an external flush request arrive in the same idle cycle, the flush is started first, even with normal memory uncached. `mint_to_core` stays low until the flush sequence has completed.
- R5: A flush started with normal memory write-back enters drain state (2) and stays there until `cache_done`. It then holds `special_cyc` high for exactly two cycles (state 3). A pending interrupt is released on the cycle after the second completion cycle.
- R6: A flush started with normal memory write-through waits in state 1 until `cache_done`. It then releases a pending interrupt on the next cycle, without any completion cycles.
- R7: The write-through or write-back choice for an entry flush is fixed when the flush starts. The private-memory setting is captured only while idle, so changes made during a sequence or while in-mode take effect at the next entry.
- R8: An external flush request in in-mode, while `mode_active` is high, produces a one-cycle `flush_cmd` on the next cycle and leaves the state at in-mode.
- R9: An external flush request in idle with no interrupt pending runs the full flush sequence for the current normal setting and then returns to idle without pulsing `mint_to_core`.
- R10: `seq_state` encodes idle 0, entry flush 1, write-back drain 2, completion cycles 3, in-mode 4 and exit flush 5.
- R11: An interrupt request that arrives while in-mode is held. It is taken as a fresh entry request once the sequencer is back in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mint_req | input | 1 | Management interrupt request, one-cycle pulse |
| ext_flush_req | input | 1 | External cache flush request |
| mode_active | input | 1 | Core reports it is executing in management mode |
| norm_mode | input | 2 | Normal-memory cacheability code |
| priv_mode | input | 2 | Private-memory cacheability code |
| cache_done | input | 1 | Cache reports that the requested flush or drain has finished |
| flush_cmd | output | 1 | One-cycle flush command to the cache |
| mint_to_core | output | 1 | One-cycle gated management interrupt to the core |
| special_cyc | output | 1 | High during each of the two completion cycles |
| seq_state | output | 3 | Current sequencing state |

## Verification
On every cycle, the assertions check four things: the exit flush lands one clock after the active indication falls, the interrupt and the flush command never coincide, a write-back drain is always followed by a completion cycle, and the held private setting never moves outside idle. They also check the direct release of the interrupt when normal memory is uncached and the in-mode flush pass-through. Only the bench scenarios can show the full entry and exit ordering for each pairing of normal and private cacheability, the exact count of completion cycles before the interrupt, the deferred delivery of an interrupt raised while in-mode, and the clearing of a pending interrupt by reset.

// File: rtl/mgmt_flush_pkg.sv
package mgmt_flush_pkg;

    typedef enum logic [1:0] {
        CM_UNCACHED = 2'b00,
        CM_WTHRU    = 2'b01,
        CM_WBACK    = 2'b10,
        CM_WBACK_X  = 2'b11
    } cache_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE        = 3'd0,
        SQ_ENTRY_FLUSH = 3'd1,
        SQ_WB_DRAIN    = 3'd2,
        SQ_SPECIAL     = 3'd3,
        SQ_IN_MODE     = 3'd4,
        SQ_EXIT_FLUSH  = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic        pend;
        logic        seen;
        logic        flush;
        logic        mint;
        logic [1:0]  priv;
    } seq_regs_t;

endpackage

// File: rtl/mgmt_flush_policy.sv
module mgmt_flush_policy (
    input  logic [1:0] norm_mode,
    input  logic [1:0] priv_mode,
    output logic       need_entry,
    output logic       entry_wb,
    output logic       need_exit
);
    // Any cached code on normal memory means stale normal lines may hide private data.
    assign need_entry = |norm_mode;
    // Codes 10 and 11 both mean write-back.
    assign entry_wb   = norm_mode[1];
    // Cached private lines must be dropped before normal code resumes.
    assign need_exit  = |priv_mode;
endmodule

// File: rtl/mgmt_flush_spcnt.sv
module mgmt_flush_spcnt #(
    parameter int N_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CNT_W = (N_CYC > 1) ? $clog2(N_CYC) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign last = run && (cnt_q == CNT_W'(N_CYC - 1));

    always_comb begin
        cnt_d = '0;
        if (run && !last) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/mgmt_flush_seq.sv
module mgmt_flush_seq
    import mgmt_flush_pkg::*;
#(
    parameter int SPECIAL_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mint_req,
    input  logic       ext_flush_req,
    input  logic       mode_active,
    input  logic [1:0] norm_mode,
    input  logic [1:0] priv_mode,
    input  logic       cache_done,
    output logic       flush_cmd,
    output logic       mint_to_core,
    output logic       special_cyc,
    output logic [2:0] seq_state
);
    seq_regs_t r_d, r_q;

    logic need_entry, entry_wb, need_exit;
    logic sp_run, sp_last;
    logic mint_seen;

    // Entry decisions use live normal setting; exit uses the held private setting.
    mgmt_flush_policy u_policy (
        .norm_mode  (norm_mode),
        .priv_mode  (r_q.priv),
        .need_entry (need_entry),
        .entry_wb   (entry_wb),
        .need_exit  (need_exit)
    );

    assign sp_run = (r_q.state == SQ_SPECIAL);

    mgmt_flush_spcnt #(.N_CYC(SPECIAL_N)) u_spcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sp_run),
        .last  (sp_last)
    );

    assign mint_seen = r_q.pend | mint_req;

    always_comb begin
        r_d       = r_q;
        r_d.flush = 1'b0;
        r_d.mint  = 1'b0;
        r_d.pend  = mint_seen;

        if (r_q.state == SQ_IDLE) begin
            r_d.priv = priv_mode;
        end

        unique case (r_q.state)
            SQ_IDLE: begin
                r_d.seen = 1'b0;
                if (ext_flush_req || (mint_seen && need_entry)) begin
                    // Flush always wins over a simultaneous interrupt.
                    r_d.flush = 1'b1;
                    r_d.state = entry_wb ? SQ_WB_DRAIN : SQ_ENTRY_FLUSH;
                end else if (mint_seen) begin
                    r_d.mint  = 1'b1;
                    r_d.pend  = 1'b0;
                    r_d.state = SQ_IN_MODE;
                end
            end
            SQ_ENTRY_FLUSH: begin
                if (cache_done) begin
                    if (mint_seen) begin
                        r_d.mint  = 1'b1;
                        r_d.pend  = 1'b0;
                        r_d.state = SQ_IN_MODE;
                    end else begin
                        r_d.state = SQ_IDLE;
                    end
                end
            end
            SQ_WB_DRAIN: begin
                if (cache_done) begin
                    r_d.state = SQ_SPECIAL;
                end
            end
            SQ_SPECIAL: begin
                if (sp_last) begin
                    if (mint_seen) begin
                        r_d.mint  = 1'b1;
                        r_d.pend  = 1'b0;
                        r_d.state = SQ_IN_MODE;
                    end else begin
                        r_d.state = SQ_IDLE;
                    end
                end
            end
            SQ_IN_MODE: begin
                if (mode_active) begin
                    r_d.seen = 1'b1;
                end
                if (r_q.seen && !mode_active) begin
                    r_d.seen = 1'b0;
                    if (need_exit || ext_flush_req) begin
                        r_d.flush = 1'b1;
                        r_d.state = SQ_EXIT_FLUSH;
                    end else begin
                        r_d.state = SQ_IDLE;
                    end
                end else if (ext_flush_req) begin
                    // Ordinary flush while the handler runs; sequencing untouched.
                    r_d.flush = 1'b1;
                end
            end
            SQ_EXIT_FLUSH: begin
                if (cache_done) begin
                    r_d.state = SQ_IDLE;
                end
            end
            default: begin
                r_d.state = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SQ_IDLE, pend: 1'b0, seen: 1'b0,
                     flush: 1'b0, mint: 1'b0, priv: 2'b00};
        end else begin
            r_q <= r_d;
        end
    end

    assign flush_cmd    = r_q.flush;
    assign mint_to_core = r_q.mint;
    assign special_cyc  = sp_run;
    assign seq_state    = r_q.state;
endmodule

// File: rtl/mgmt_flush_seq_chk.sv
module mgmt_flush_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mint_req,
    input logic       ext_flush_req,
    input logic       mode_active,
    input logic [1:0] norm_mode,
    input logic       cache_done,
    input logic       flush_cmd,
    input logic       mint_to_core,
    input logic       special_cyc,
    input logic [2:0] seq_state,
    input logic [1:0] held_priv
);
    assert_exit_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd4 && $fell(mode_active) && held_priv != 2'b00)
        |=> (flush_cmd && seq_state == 3'd5));

    assert_no_exit_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd4 && $fell(mode_active) && held_priv == 2'b00 && !ext_flush_req)
        |=> (!flush_cmd && seq_state == 3'd0));

    assert_direct_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd0 && mint_req && !ext_flush_req && norm_mode == 2'b00)
        |=> (mint_to_core && seq_state == 3'd4));

    assert_flush_before_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mint_to_core |-> !flush_cmd);

    assert_drain_then_special_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd2 && cache_done) |=> special_cyc);

    assert_priv_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seq_state) != 3'd0) |-> $stable(held_priv));

    assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 3'd4 && mode_active && ext_flush_req)
        |=> (flush_cmd && seq_state == 3'd4));
endmodule

bind mgmt_flush_seq mgmt_flush_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mint_req      (mint_req),
    .ext_flush_req (ext_flush_req),
    .mode_active   (mode_active),
    .norm_mode     (norm_mode),
    .cache_done    (cache_done),
    .flush_cmd     (flush_cmd),
    .mint_to_core  (mint_to_core),
    .special_cyc   (special_cyc),
    .seq_state     (seq_state),
    .held_priv     (r_q.priv)
);

// File: tb/mgmt_flush_seq_test.sv
module mgmt_flush_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mint_req = 1'b0;
    logic       ext_flush_req = 1'b0;
    logic       mode_active = 1'b0;
    logic [1:0] norm_mode = 2'b00;
    logic [1:0] priv_mode = 2'b00;
    logic       cache_done = 1'b0;
    logic       flush_cmd, mint_to_core, special_cyc;
    logic [2:0] seq_state;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    mgmt_flush_seq uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mint_req      (mint_req),
        .ext_flush_req (ext_flush_req),
        .mode_active   (mode_active),
        .norm_mode     (norm_mode),
        .priv_mode     (priv_mode),
        .cache_done    (cache_done),
        .flush_cmd     (flush_cmd),
        .mint_to_core  (mint_to_core),
        .special_cyc   (special_cyc),
        .seq_state     (seq_state)
    );

    // {norm[1:0], priv[1:0], pad, entry flush, write-back, exit flush}
    localparam logic [7:0] VEC [8] = '{
        8'b00_00_0_000,
        8'b00_01_0_001,
        8'b01_00_0_100,
        8'b10_00_0_110,
        8'b01_01_0_101,
        8'b10_01_0_111,
        8'b11_10_0_111,
        8'b00_10_0_001
    };

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic leave_mode();
        mode_active = 1'b1; cyc(); cyc();
        mode_active = 1'b0; cyc();
    endtask

    task automatic run_mode(logic [1:0] n, logic [1:0] p, logic e, logic w, logic x);
        norm_mode = n; priv_mode = p;
        mint_req = 1'b1; cyc(); mint_req = 1'b0;
        if (e) begin
            chk("R2", flush_cmd, 1, "entry flush issued");
            chk("R2", mint_to_core, 0, "interrupt held during flush");
            if (w) begin
                chk("R5", seq_state, 2, "drain state");
                cyc();
                chk("R5", seq_state, 2, "drain waits for done");
                cache_done = 1'b1; cyc(); cache_done = 1'b0;
                chk("R5", special_cyc, 1, "first completion cycle");
                cyc();
                chk("R5", special_cyc, 1, "second completion cycle");
                chk("R5", mint_to_core, 0, "no interrupt before completion ends");
                cyc();
                chk("R5", special_cyc, 0, "only two completion cycles");
                chk("R5", mint_to_core, 1, "interrupt after completion");
            end else begin
                chk("R6", seq_state, 1, "entry flush state");
                cyc();
                chk("R6", seq_state, 1, "waits for done");
                cache_done = 1'b1; cyc(); cache_done = 1'b0;
                chk("R6", mint_to_core, 1, "interrupt after done");
                chk("R6", special_cyc, 0, "no completion cycles");
            end
        end else begin
            chk("R2", mint_to_core, 1, "direct interrupt");
            chk("R2", flush_cmd, 0, "no entry flush");
        end
        chk("R10", seq_state, 4, "in-mode code");
        leave_mode();
        chk("R3", flush_cmd, x, "exit flush one clock after drop");
        if (x) begin
            chk("R3", seq_state, 5, "exit flush state");
            cache_done = 1'b1; cyc(); cache_done = 1'b0;
        end
        chk("R3", seq_state, 0, "back to idle");
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        cyc(); cyc();
        chk("R1", seq_state, 0, "reset state");
        chk("R1", {5'b0, flush_cmd, mint_to_core, special_cyc}, 0, "reset outputs");
        rst_n = 1'b1;
        cyc();

        for (int i = 0; i < 8; i++) begin
            run_mode(VEC[i][7:6], VEC[i][5:4], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R4: simultaneous request, write-through normal memory
        norm_mode = 2'b01; priv_mode = 2'b00;
        mint_req = 1'b1; ext_flush_req = 1'b1; cyc();
        mint_req = 1'b0; ext_flush_req = 1'b0;
        chk("R4", flush_cmd, 1, "flush taken first");
        chk("R4", mint_to_core, 0, "interrupt held");
        chk("R4", seq_state, 1, "entry flush state");
        cyc();
        chk("R4", mint_to_core, 0, "still held before done");
        cache_done = 1'b1; cyc(); cache_done = 1'b0;
        chk("R4", mint_to_core, 1, "released after flush");
        leave_mode();
        chk("R4", seq_state, 0, "idle after exit");

        // R4: simultaneous request with normal memory uncached
        norm_mode = 2'b00;
        mint_req = 1'b1; ext_flush_req = 1'b1; cyc();
        mint_req = 1'b0; ext_flush_req = 1'b0;
        chk("R4", flush_cmd, 1, "flush first with uncached normal");
        chk("R4", seq_state, 1, "entry flush state uncached");
        cache_done = 1'b1; cyc(); cache_done = 1'b0;
        chk("R4", mint_to_core, 1, "released after flush uncached");
        leave_mode();

        // R9: external flush only, write-back normal memory
        norm_mode = 2'b10;
        ext_flush_req = 1'b1; cyc(); ext_flush_req = 1'b0;
        chk("R9", seq_state, 2, "drain on plain flush");
        cache_done = 1'b1; cyc(); cache_done = 1'b0;
        cyc(); cyc();
        chk("R9", seq_state, 0, "returns to idle");
        chk("R9", mint_to_core, 0, "no interrupt");

        // R7: settings changed mid-sequence and in-mode are not used
        norm_mode = 2'b01; priv_mode = 2'b00;
        mint_req = 1'b1; cyc(); mint_req = 1'b0;
        norm_mode = 2'b10;
        cyc();
        cache_done = 1'b1; cyc(); cache_done = 1'b0;
        chk("R7", mint_to_core, 1, "flush kind fixed at start");
        chk("R7", special_cyc, 0, "no completion cycles added");
        priv_mode = 2'b01;
        leave_mode();
        chk("R7", flush_cmd, 0, "private change in-mode ignored");
        chk("R7", seq_state, 0, "idle after exit");
        norm_mode = 2'b00; priv_mode = 2'b01;
        mint_req = 1'b1; cyc(); mint_req = 1'b0;
        priv_mode = 2'b00;
        leave_mode();
        chk("R7", flush_cmd, 1, "held private setting drives exit flush");
        cache_done = 1'b1; cyc(); cache_done = 1'b0;
        chk("R7", seq_state, 0, "idle after exit flush");

        // R8: pass-through flush while in-mode
        mint_req = 1'b1; cyc(); mint_req = 1'b0;
        mode_active = 1'b1; cyc();
        ext_flush_req = 1'b1; cyc(); ext_flush_req = 1'b0;
        chk("R8", flush_cmd, 1, "pass-through flush");
        chk("R8", seq_state, 4, "state unchanged");
        cyc();
        chk("R8", flush_cmd, 0, "single-cycle flush");
        mode_active = 1'b0; cyc();
        chk("R8", seq_state, 0, "normal exit after pass-through");

        // R11: interrupt raised while in-mode is delivered after return
        mint_req = 1'b1; cyc(); mint_req = 1'b0;
        mode_active = 1'b1; cyc();
        mint_req = 1'b1; cyc(); mint_req = 1'b0;
        chk("R11", mint_to_core, 0, "no delivery in-mode");
        mode_active = 1'b0; cyc();
        chk("R11", seq_state, 0, "exit to idle");
        cyc();
        chk("R11", mint_to_core, 1, "held interrupt delivered");
        chk("R11", seq_state, 4, "re-entered mode");
        leave_mode();

        // R1: reset mid-sequence clears the pending interrupt
        norm_mode = 2'b01;
        mint_req = 1'b1; cyc(); mint_req = 1'b0;
        rst_n = 1'b0; cyc();
        chk("R1", seq_state, 0, "reset mid-sequence");
        rst_n = 1'b1; norm_mode = 2'b00;
        cyc(); cyc();
        chk("R1", mint_to_core, 0, "pending cleared by reset");
        chk("R1", seq_state, 0, "stays idle");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule